// File: doc/BRIEF.md
# Event-Triggered Preemptive Channel Scheduler

This block decides which of 32 logical DMA channels owns a single shared execution engine at any moment. Forty-eight hardware event lines come in. A programmable routing matrix connects each event to any set of channels, including several channels at once. A rising edge on an event marks each routed channel that is enabled as pending. The scheduler then picks the most urgent pending channel and hands it to the engine through a request and acknowledge handshake.

Each channel has a 3-bit priority. The values 4 to 7 form an upper level and the values 1 to 3 form a lower level. A pending channel in the upper level forces a switch away from a running channel in the lower level. Channels in the same level never displace each other. The engine reports completion with a done strobe that carries the channel number. That strobe clears the channel's pending flag and frees the engine for the next selection.

Software sets up the block through one write port. The write kind picks the target: kind 0 writes one event's channel mask, kind 1 writes one channel's priority, and kind 2 writes the 32-bit channel enable mask.

Top module: `evsched_top`

## Requirements
- R1: After synchronous reset, sw_req and run_valid are 0, every pending flag is clear, every routing mask is zero, and every priority is 0. sw_req and run_valid are never 1 in the same cycle.
- R2: A write with cfg_kind=0 stores cfg_wdata as the channel mask of event cfg_addr, where bit i means channel i. A 0-to-1 transition on evt_in[e] sets the pending flag of every channel in that mask. One event can trigger several channels.
- R3: An event edge that arrives while the target channel is already pending is absorbed. An event input held high does not trigger again. Each pending period produces exactly one run.
- R4: A channel whose bit in the enable mask (write kind 2, bit i = channel i) is 0 ignores event edges. Setting the enable bit later does not create a run from an earlier edge.
- R5: A channel with priority 0 (write kind 1, cfg_wdata[2:0]) is never granted, but it keeps its pending flag. Once it is given a nonzero priority, it is granted.
- R6: When the engine is free, the pending channel with the highest priority is selected. Among channels of equal priority, the lowest channel number wins.
- R7: sw_req stays high with a constant sw_ch until sw_ack is sampled high. In the cycle after the acknowledge, sw_req is 0, run_valid is 1 and run_ch equals the acknowledged sw_ch.
- R8: While a channel with priority 1 to 3 runs, a pending channel with priority 4 to 7 makes the block raise sw_req for that channel on the next cycle. The displaced channel stays pending and runs again later.
- R9: A pending channel whose priority level is the same as the running channel's level causes no switch, even if its priority value is higher.
- R10: A done_valid strobe whose done_ch matches run_ch clears that channel's pending flag and drops run_valid on the next cycle. A done strobe with a different channel has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | 0 = event mask, 1 = channel priority, 2 = enable mask |
| cfg_addr | input | 6 | Event index (kind 0) or channel index (kind 1) |
| cfg_wdata | input | 32 | Write data |
| evt_in | input | 48 | Hardware event lines |
| sw_req | output | 1 | Switch request to the engine |
| sw_ch | output | 5 | Channel the switch targets |
| sw_ack | input | 1 | Engine accepts the switch |
| run_valid | output | 1 | A channel owns the engine |
| run_ch | output | 5 | Owning channel |
| done_valid | input | 1 | Engine reports a channel finished |
| done_ch | input | 5 | Channel that finished |

## Verification
The bench fires one event into two equal-priority channels. A design with a reversed tie-break would grant channel 9 before channel 5. It holds an event high and re-pulses it during a run. A level-sensitive or counting pending flag would then produce a second grant. It starts an upper-level channel during a lower-level run and expects a switch and a later resumption of the displaced channel. It also starts a higher lower-level channel and expects no switch, which catches a preemption test that compares raw values instead of levels. Priority-0 and disabled channels are watched for stray grants, and a slow acknowledge checks that sw_ch does not drift while the request waits.

// File: rtl/evsched_pkg.sv
package evsched_pkg;
    localparam int NCH = 32;
    localparam int NEV = 48;
    localparam int PW  = 3;
    localparam int CHW = $clog2(NCH);
    localparam int EVW = $clog2(NEV);
    localparam int AW  = (EVW > CHW) ? EVW : CHW;

    typedef logic [PW-1:0]          prio_t;
    typedef logic [NCH-1:0]         chmask_t;
    typedef logic [CHW-1:0]         ch_t;
    typedef logic [NCH-1:0][PW-1:0] prio_vec_t;

    typedef enum logic [1:0] {
        CFG_MAP  = 2'd0,
        CFG_PRIO = 2'd1,
        CFG_EN   = 2'd2
    } cfg_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SWITCH = 2'd1,
        ST_RUN    = 2'd2
    } sched_st_e;

    typedef struct packed {
        logic  valid;
        ch_t   ch;
        prio_t prio;
    } pick_t;

    function automatic logic upper_level(prio_t p);
        return p[PW-1];
    endfunction

    function automatic chmask_t ch_onehot(ch_t c);
        return chmask_t'(1) << c;
    endfunction
endpackage

// File: rtl/evsched_router.sv
module evsched_router
    import evsched_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_we,
    input  cfg_kind_e      cfg_kind,
    input  logic [AW-1:0]  cfg_addr,
    input  chmask_t        cfg_wdata,
    input  logic [NEV-1:0] evt_in,
    output chmask_t        trig
);
    chmask_t        map_q [NEV];
    logic [NEV-1:0] evt_q;
    logic [NEV-1:0] rise;

    assign rise = evt_in & ~evt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= '0;
            for (int e = 0; e < NEV; e++) map_q[e] <= '0;
        end else begin
            evt_q <= evt_in;
            if (cfg_we && cfg_kind == CFG_MAP && int'(cfg_addr) < NEV)
                map_q[cfg_addr] <= cfg_wdata;
        end
    end

    always_comb begin
        trig = '0;
        for (int e = 0; e < NEV; e++)
            if (rise[e]) trig = trig | map_q[e];
    end

    // R3
    held_level_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_in != '0) |=> ((rise & $past(evt_in)) == '0));
endmodule

// File: rtl/evsched_chtab.sv
module evsched_chtab
    import evsched_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  cfg_kind_e     cfg_kind,
    input  logic [AW-1:0] cfg_addr,
    input  chmask_t       cfg_wdata,
    input  chmask_t       trig,
    input  chmask_t       clr,
    output prio_vec_t     prio_vec,
    output chmask_t       ready
);
    chmask_t   en_q;
    chmask_t   pend_q;
    prio_vec_t prio_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pend_q <= '0;
            prio_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr) | (trig & en_q);
            if (cfg_we && cfg_kind == CFG_EN)
                en_q <= cfg_wdata;
            if (cfg_we && cfg_kind == CFG_PRIO && int'(cfg_addr) < NCH)
                prio_q[cfg_addr[CHW-1:0]] <= cfg_wdata[PW-1:0];
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_rdy
        assign ready[i] = pend_q[i] && (prio_q[i] != '0);
    end

    assign prio_vec = prio_q;

    // R4
    en_gate_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0));
endmodule

// File: rtl/evsched_pick.sv
module evsched_pick
    import evsched_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  chmask_t   cand,
    input  prio_vec_t prio_vec,
    output pick_t     pick
);
    always_comb begin
        pick = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (cand[i] && (!pick.valid || prio_vec[i] >= pick.prio)) begin
                pick.valid = 1'b1;
                pick.ch    = ch_t'(i);
                pick.prio  = prio_vec[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && pick.valid) begin
            for (int i = 0; i < NCH; i++) begin
                if (cand[i]) begin
                    // R6
                    best_prio_chk: assert (prio_vec[i] <= pick.prio);
                    // R6
                    low_index_chk: assert (prio_vec[i] != pick.prio || i >= int'(pick.ch));
                end
            end
        end
    end
endmodule

// File: rtl/evsched_top.sv
module evsched_top
    import evsched_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_we,
    input  logic [1:0]     cfg_kind,
    input  logic [AW-1:0]  cfg_addr,
    input  logic [NCH-1:0] cfg_wdata,
    input  logic [NEV-1:0] evt_in,
    output logic           sw_req,
    output logic [CHW-1:0] sw_ch,
    input  logic           sw_ack,
    output logic           run_valid,
    output logic [CHW-1:0] run_ch,
    input  logic           done_valid,
    input  logic [CHW-1:0] done_ch
);
    sched_st_e st_q;
    ch_t       sw_ch_q;
    ch_t       run_ch_q;
    chmask_t   trig;
    chmask_t   clr;
    chmask_t   ready;
    chmask_t   cand;
    prio_vec_t prio_vec;
    pick_t     pick;
    cfg_kind_e kind;
    logic      done_hit;
    logic      preempt;

    assign kind = cfg_kind_e'(cfg_kind);

    evsched_router u_router (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_kind  (kind),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .evt_in    (evt_in),
        .trig      (trig)
    );

    evsched_chtab u_chtab (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_kind  (kind),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .trig      (trig),
        .clr       (clr),
        .prio_vec  (prio_vec),
        .ready     (ready)
    );

    assign cand = (st_q == ST_RUN) ? (ready & ~ch_onehot(run_ch_q)) : ready;

    evsched_pick u_pick (
        .clk      (clk),
        .rst      (rst),
        .cand     (cand),
        .prio_vec (prio_vec),
        .pick     (pick)
    );

    assign done_hit = (st_q == ST_RUN) && done_valid && (done_ch == run_ch_q);
    assign clr      = done_hit ? ch_onehot(run_ch_q) : '0;
    assign preempt  = (st_q == ST_RUN) && !done_hit && pick.valid &&
                      upper_level(pick.prio) && !upper_level(prio_vec[run_ch_q]);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            sw_ch_q  <= '0;
            run_ch_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (pick.valid) begin
                    st_q    <= ST_SWITCH;
                    sw_ch_q <= pick.ch;
                end
                ST_SWITCH: if (sw_ack) begin
                    st_q     <= ST_RUN;
                    run_ch_q <= sw_ch_q;
                end
                ST_RUN: if (done_hit) begin
                    st_q <= ST_IDLE;
                end else if (preempt) begin
                    st_q    <= ST_SWITCH;
                    sw_ch_q <= pick.ch;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign sw_req    = (st_q == ST_SWITCH);
    assign sw_ch     = sw_ch_q;
    assign run_valid = (st_q == ST_RUN);
    assign run_ch    = run_ch_q;

    // R1
    excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(sw_req && run_valid));
    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_req && !sw_ack) |=> (sw_req && $stable(sw_ch)));
    // R7
    ack_run_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_req && sw_ack) |=> (run_valid && !sw_req && run_ch == $past(sw_ch)));
    // R9
    upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (run_valid && upper_level(prio_vec[run_ch]) && !(done_valid && done_ch == run_ch))
        |=> !sw_req);
    // R10
    done_end_chk: assert property (@(posedge clk) disable iff (rst)
        (run_valid && done_valid && done_ch == run_ch) |=> !run_valid);
    // R10
    stray_done_chk: assert property (@(posedge clk) disable iff (rst)
        (run_valid && !(done_valid && done_ch == run_ch) && !preempt) |=> run_valid);
endmodule

// File: tb/evsched_top_test.sv
module evsched_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_kind = 2'd0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [47:0] evt_in = '0;
    logic        sw_req;
    logic [4:0]  sw_ch;
    logic        sw_ack = 1'b0;
    logic        run_valid;
    logic [4:0]  run_ch;
    logic        done_valid = 1'b0;
    logic [4:0]  done_ch = '0;

    int checks = 0;
    int fails = 0;
    int exp_q[$];
    int ack_lat = 0;
    int wcnt = 0;
    logic seen = 1'b0;
    logic [4:0] held_ch = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    evsched_top uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .evt_in(evt_in),
        .sw_req(sw_req), .sw_ch(sw_ch), .sw_ack(sw_ack),
        .run_valid(run_valid), .run_ch(run_ch),
        .done_valid(done_valid), .done_ch(done_ch)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pops the expected grant order and acknowledges after ack_lat cycles
    always @(negedge clk) begin
        if (rst) begin
            sw_ack <= 1'b0;
            seen = 1'b0;
        end else if (sw_req && !sw_ack) begin
            if (!seen) begin
                if (exp_q.size() == 0) chk(1'b0, "R6 unexpected grant", int'(sw_ch), -1);
                else begin
                    automatic int e = exp_q.pop_front();
                    chk(int'(sw_ch) == e, "R6 grant order", int'(sw_ch), e);
                end
                seen = 1'b1;
                held_ch = sw_ch;
                wcnt = 0;
            end else begin
                chk(sw_ch == held_ch, "R7 sw_ch held", int'(sw_ch), int'(held_ch));
            end
            if (wcnt >= ack_lat) sw_ack <= 1'b1;
            else wcnt = wcnt + 1;
        end else begin
            sw_ack <= 1'b0;
            seen = 1'b0;
        end
    end

    task automatic cfg(input int kind, input int addr, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = 2'(kind); cfg_addr = 6'(addr); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input int ev);
        @(negedge clk);
        evt_in[ev] = 1'b1;
        @(negedge clk);
        evt_in[ev] = 1'b0;
    endtask

    task automatic wait_run(input int ch, input string req);
        int n = 0;
        while (!run_valid && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(run_valid && int'(run_ch) == ch, req, int'(run_ch), ch);
        chk(!sw_req, "R7 req dropped", int'(sw_req), 0);
    endtask

    task automatic finish_run(input string req);
        automatic int c = int'(run_ch);
        @(negedge clk);
        done_valid = 1'b1; done_ch = 5'(c);
        @(negedge clk);
        done_valid = 1'b0;
        chk(!run_valid, req, int'(run_valid), 0);
    endtask

    task automatic quiet(input int n, input string req);
        logic bad = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sw_req) bad = 1'b1;
        end
        chk(!bad, req, int'(bad), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        @(negedge clk);
        chk(!sw_req && !run_valid, "R1 reset outputs", int'(sw_req) + int'(run_valid), 0);

        cfg(2, 0, 32'hFFFE_FFFF); // all enabled except channel 16

        // R2 / R6: one event to two equal-priority channels, lowest index first
        cfg(1, 5, 32'd2); cfg(1, 9, 32'd2);
        cfg(0, 3, (32'd1 << 5) | (32'd1 << 9));
        exp_q.push_back(5); exp_q.push_back(9);
        pulse(3);
        wait_run(5, "R2 first routed channel");
        finish_run("R10 done clears");
        wait_run(9, "R2 second routed channel");
        finish_run("R10 done clears");

        // R6: higher priority first; R7 with slow acknowledge
        ack_lat = 3;
        cfg(1, 20, 32'd6); cfg(1, 2, 32'd1);
        cfg(0, 10, (32'd1 << 20) | (32'd1 << 2));
        exp_q.push_back(20); exp_q.push_back(2);
        pulse(10);
        wait_run(20, "R6 higher priority wins");
        finish_run("R10 done clears");
        wait_run(2, "R7 run after slow ack");
        ack_lat = 0;
        // R10: stray done for another channel is ignored
        @(negedge clk);
        done_valid = 1'b1; done_ch = 5'd7;
        @(negedge clk);
        done_valid = 1'b0;
        @(negedge clk);
        chk(run_valid && run_ch == 5'd2, "R10 stray done ignored", int'(run_ch), 2);
        finish_run("R10 done clears");

        // R8: upper-level channel preempts a lower-level run
        cfg(0, 11, 32'd1 << 2);
        cfg(1, 30, 32'd5);
        cfg(0, 12, 32'd1 << 30);
        exp_q.push_back(2); exp_q.push_back(30); exp_q.push_back(2);
        pulse(11);
        wait_run(2, "R8 lower channel starts");
        pulse(12);
        @(negedge clk);
        wait_run(30, "R8 preempting channel runs");
        finish_run("R10 done clears");
        wait_run(2, "R8 displaced channel resumes");
        finish_run("R10 done clears");

        // R9: same level, higher value, no switch
        cfg(1, 7, 32'd2); cfg(1, 1, 32'd3);
        cfg(0, 13, 32'd1 << 7); cfg(0, 14, 32'd1 << 1);
        exp_q.push_back(7); exp_q.push_back(1);
        pulse(13);
        wait_run(7, "R9 lower run starts");
        pulse(14);
        quiet(10, "R9 no same-level switch");
        chk(run_valid && run_ch == 5'd7, "R9 run kept", int'(run_ch), 7);
        finish_run("R10 done clears");
        wait_run(1, "R9 waiting channel runs");
        finish_run("R10 done clears");

        // R9 upper level vs upper level
        cfg(1, 31, 32'd7);
        cfg(0, 15, 32'd1 << 31);
        exp_q.push_back(30); exp_q.push_back(31);
        pulse(12);
        wait_run(30, "R9 upper run starts");
        pulse(15);
        quiet(8, "R9 upper not preempted");
        finish_run("R10 done clears");
        wait_run(31, "R9 upper waiting runs");
        finish_run("R10 done clears");

        // R3: repeated and held events absorbed while pending
        cfg(1, 4, 32'd2);
        cfg(0, 20, 32'd1 << 4); cfg(0, 21, 32'd1 << 4);
        exp_q.push_back(4);
        pulse(20);
        wait_run(4, "R3 single run starts");
        pulse(20);
        @(negedge clk); evt_in[21] = 1'b1;
        @(negedge clk);
        finish_run("R10 done clears");
        quiet(10, "R3 no second run");
        evt_in[21] = 1'b0;

        // R5: priority 0 never granted, pending kept
        cfg(0, 30, 32'd1 << 15);
        pulse(30);
        quiet(8, "R5 priority zero not granted");
        exp_q.push_back(15);
        cfg(1, 15, 32'd3);
        wait_run(15, "R5 granted after priority set");
        finish_run("R10 done clears");

        // R4: disabled channel ignores events
        cfg(1, 16, 32'd2);
        cfg(0, 31, 32'd1 << 16);
        pulse(31);
        quiet(8, "R4 disabled ignores event");
        cfg(2, 0, 32'hFFFF_FFFF);
        quiet(8, "R4 enable does not replay");

        chk(exp_q.size() == 0, "R6 all grants seen", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule